// File: doc/BRIEF.md
# Calibration Pulse Waveform Generator

This block drives the analog switches of a built-in self-test voltage source that is injected into a sensing channel. It runs from a 32.768 kHz reference clock. From that clock it builds a rectangular test waveform whose period can be set in steps of four, from 128 clock cycles (256 Hz) up to 2,097,152 cycles (about 15.6 mHz). The high phase of each period either lasts a programmed number of clock cycles or covers exactly half the period.

The waveform leaves the block as two strobes. `drive_pos` connects the +amplitude source. `drive_neg` connects the −amplitude source. When both strobes are low, the output sits at mid level. In unipolar operation the low phase rests at mid level. In bipolar operation the low phase swings to −amplitude. An amplitude select and a routing code (single-ended, differential or common mode) pass through to the analog side, each delayed by one register. An interlock input reports whether the subject isolation switches are closed. While they are, the strobes stay at mid level and a blocked flag is raised.

Timing settings are taken up only at a period boundary, so a reprogrammed waveform never produces a runt pulse. The asynchronous reset is released through a two-flop synchronizer.

Top module: `cal_pulse_gen`

## Requirements
- R1: For frequency code k (0 to 7), the waveform period is 2^(BASE_LOG2+2k) clock cycles. With the default BASE_LOG2 = 7, code 0 gives 128 cycles (256 Hz) and code 7 gives 2^21 cycles.
- R2: With `half_duty` = 0, the high phase lasts `width_cnt` cycles, counted from the start of each period. A count of 0 gives no high phase.
- R3: With `half_duty` = 0, a `width_cnt` larger than half the period is clamped, so the high phase lasts exactly half the period.
- R4: With `half_duty` = 1, the high phase lasts exactly half the period and `width_cnt` has no effect.
- R5: During the high phase `drive_pos` = 1 and `drive_neg` = 0. During the low phase `drive_pos` = 0, and `drive_neg` equals `bipolar` (1 = bipolar, 0 = unipolar mid level). The two strobes are never high together.
- R6: A change to `freq_code`, `width_cnt` or `half_duty` while the block is enabled takes effect only at the next period boundary.
- R7: While `enable` = 0, the period counter is held at the start and both strobes and `cal_blocked` are low one cycle later. After `enable` rises, the first output cycle is period position 0, which is in the high phase whenever the high time is non-zero.
- R8: While enabled with `iso_closed` = 1, both strobes are low and `cal_blocked` = 1 one cycle later. The period counter keeps running.
- R9: `mag_out` (0 = smaller step, 1 = larger step) follows `mag_sel`, and `route_out` follows `route_mode`, each one cycle later.
- R10: During reset, and until two clock edges after reset is released, all outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 32.768 kHz reference clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Runs the waveform; low holds the counter at the start |
| freq_code | input | CODE_W (3) | Period select k; the period is 2^(BASE_LOG2+2k) cycles |
| width_cnt | input | WIDTH_W (11) | High-phase length in clock cycles |
| half_duty | input | 1 | 1 forces a high phase of exactly half the period |
| bipolar | input | 1 | 1 drives −amplitude during the low phase |
| mag_sel | input | 1 | Amplitude step select |
| route_mode | input | ROUTE_W (2) | Routing code passed to the analog side |
| iso_closed | input | 1 | Isolation switches closed; blocks the drive |
| drive_pos | output | 1 | +amplitude strobe |
| drive_neg | output | 1 | −amplitude strobe |
| mag_out | output | 1 | Registered amplitude select |
| route_out | output | ROUTE_W (2) | Registered routing code |
| cal_blocked | output | 1 | Drive held at mid level by the interlock |

## Verification
Every output comes from a register. The strobes for period position j therefore appear after the j-th clock edge that has `enable` high, counted from 0. The interlock, `mag_out` and `route_out` respond after the first edge that samples a change, and a timing change mid-period first shows up in the output cycle after the boundary edge. The bench drives inputs on the falling edge and samples a quarter period after each rising edge. It compares every cycle against a reference model written from the requirements, which applies the same one-register delay. Directed runs count high and low cycles over a whole period, and confirm that the next period starts exactly one period later.

// File: rtl/cal_pkg.sv
package cal_pkg;
  parameter int unsigned CAL_NCODES  = 8;
  parameter int unsigned CAL_WIDTH_W = 11;
  parameter int unsigned CAL_ROUTE_W = 2;

  typedef struct packed {
    logic pos;
    logic neg;
  } cal_drive_t;
endpackage

// File: rtl/cal_timebase.sv
module cal_timebase #(
  parameter int unsigned BASE_LOG2 = 7,
  parameter int unsigned NCODES    = 8,
  parameter int unsigned CODE_W    = 3,
  parameter int unsigned WIDTH_W   = 11,
  parameter int unsigned CNT_W     = BASE_LOG2 + 2*(NCODES-1)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               enable,
  input  logic [CODE_W-1:0]  freq_code,
  input  logic [WIDTH_W-1:0] width_cnt,
  input  logic               half_duty,
  output logic [CNT_W-1:0]   cnt_q,
  output logic [CNT_W-1:0]   half_len,
  output logic [CODE_W-1:0]  act_code_q,
  output logic [WIDTH_W-1:0] act_width_q,
  output logic               act_half_q
);
  localparam logic [CODE_W:0] MAX_CODE = (CODE_W+1)'(NCODES-1);

  logic [CODE_W:0]  steps_down;
  logic [CNT_W-1:0] last_cnt;
  logic             wrap;
  logic             load_en;
  logic [CNT_W-1:0] cnt_d;

  always_comb begin
    steps_down = MAX_CODE - {1'b0, act_code_q};
    last_cnt   = {CNT_W{1'b1}} >> {steps_down, 1'b0};
    half_len   = (last_cnt >> 1) + 1'b1;
    wrap       = (cnt_q == last_cnt);
    load_en    = !enable || wrap;
    if (load_en) cnt_d = '0;
    else         cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q       <= '0;
      act_code_q  <= '0;
      act_width_q <= '0;
      act_half_q  <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      if (load_en) begin
        act_code_q  <= freq_code;
        act_width_q <= width_cnt;
        act_half_q  <= half_duty;
      end
    end
  end
endmodule

// File: rtl/cal_shaper.sv
module cal_shaper import cal_pkg::*; #(
  parameter int unsigned CNT_W   = 21,
  parameter int unsigned WIDTH_W = 11,
  parameter int unsigned ROUTE_W = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               enable,
  input  logic               iso_closed,
  input  logic               bipolar,
  input  logic               mag_sel,
  input  logic [ROUTE_W-1:0] route_mode,
  input  logic [CNT_W-1:0]   cnt_q,
  input  logic [CNT_W-1:0]   half_len,
  input  logic [WIDTH_W-1:0] act_width_q,
  input  logic               act_half_q,
  output logic               drive_pos,
  output logic               drive_neg,
  output logic               mag_out,
  output logic [ROUTE_W-1:0] route_out,
  output logic               cal_blocked
);
  localparam int unsigned CMP_W = (CNT_W > WIDTH_W) ? CNT_W : WIDTH_W;

  logic [CMP_W-1:0] half_x, wid_x, high_x, cnt_x;
  logic             in_high;
  cal_drive_t       drv_d, drv_q;
  logic             blk_d;

  always_comb begin
    half_x = CMP_W'(half_len);
    wid_x  = CMP_W'(act_width_q);
    cnt_x  = CMP_W'(cnt_q);
    if (act_half_q)           high_x = half_x;
    else if (wid_x > half_x)  high_x = half_x;
    else                      high_x = wid_x;
    in_high = (cnt_x < high_x);

    blk_d = enable && iso_closed;
    if (!enable || iso_closed) begin
      drv_d.pos = 1'b0;
      drv_d.neg = 1'b0;
    end else begin
      drv_d.pos = in_high;
      drv_d.neg = !in_high && bipolar;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      drv_q       <= '0;
      cal_blocked <= 1'b0;
      mag_out     <= 1'b0;
      route_out   <= '0;
    end else begin
      drv_q       <= drv_d;
      cal_blocked <= blk_d;
      mag_out     <= mag_sel;
      route_out   <= route_mode;
    end
  end

  assign drive_pos = drv_q.pos;
  assign drive_neg = drv_q.neg;
endmodule

// File: rtl/cal_pulse_gen.sv
module cal_pulse_gen import cal_pkg::*; #(
  parameter int unsigned BASE_LOG2 = 7,
  parameter int unsigned NCODES    = CAL_NCODES,
  parameter int unsigned CODE_W    = $clog2(CAL_NCODES),
  parameter int unsigned WIDTH_W   = CAL_WIDTH_W,
  parameter int unsigned ROUTE_W   = CAL_ROUTE_W
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               enable,
  input  logic [CODE_W-1:0]  freq_code,
  input  logic [WIDTH_W-1:0] width_cnt,
  input  logic               half_duty,
  input  logic               bipolar,
  input  logic               mag_sel,
  input  logic [ROUTE_W-1:0] route_mode,
  input  logic               iso_closed,
  output logic               drive_pos,
  output logic               drive_neg,
  output logic               mag_out,
  output logic [ROUTE_W-1:0] route_out,
  output logic               cal_blocked
);
  localparam int unsigned CNT_W = BASE_LOG2 + 2*(NCODES-1);

  logic               rst_meta_q, rst_sync_n;
  logic [CNT_W-1:0]   cnt_q, half_len;
  logic [CODE_W-1:0]  act_code_q;
  logic [WIDTH_W-1:0] act_width_q;
  logic               act_half_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_n <= rst_meta_q;
    end
  end

  cal_timebase #(
    .BASE_LOG2(BASE_LOG2), .NCODES(NCODES), .CODE_W(CODE_W),
    .WIDTH_W(WIDTH_W), .CNT_W(CNT_W)
  ) u_tb (
    .clk(clk), .rst_n(rst_sync_n), .enable(enable),
    .freq_code(freq_code), .width_cnt(width_cnt), .half_duty(half_duty),
    .cnt_q(cnt_q), .half_len(half_len), .act_code_q(act_code_q),
    .act_width_q(act_width_q), .act_half_q(act_half_q)
  );

  cal_shaper #(
    .CNT_W(CNT_W), .WIDTH_W(WIDTH_W), .ROUTE_W(ROUTE_W)
  ) u_sh (
    .clk(clk), .rst_n(rst_sync_n), .enable(enable),
    .iso_closed(iso_closed), .bipolar(bipolar), .mag_sel(mag_sel),
    .route_mode(route_mode), .cnt_q(cnt_q), .half_len(half_len),
    .act_width_q(act_width_q), .act_half_q(act_half_q),
    .drive_pos(drive_pos), .drive_neg(drive_neg), .mag_out(mag_out),
    .route_out(route_out), .cal_blocked(cal_blocked)
  );
endmodule

// File: rtl/cal_pulse_gen_chk.sv
module cal_pulse_gen_chk #(
  parameter int unsigned CNT_W  = 21,
  parameter int unsigned CODE_W = 3
) (
  input logic              clk,
  input logic              rst_n,
  input logic              enable,
  input logic              iso_closed,
  input logic              bipolar,
  input logic              mag_sel,
  input logic              drive_pos,
  input logic              drive_neg,
  input logic              mag_out,
  input logic              cal_blocked,
  input logic [CNT_W-1:0]  cnt,
  input logic [CODE_W-1:0] act_code
);
  // R5
  no_overlap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(drive_pos && drive_neg));

  // R5
  unipolar_rest_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !bipolar |=> !drive_neg);

  // R7
  disabled_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |=> (!drive_pos && !drive_neg && !cal_blocked));

  // R8
  iso_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (enable && iso_closed) |=> (cal_blocked && !drive_pos && !drive_neg));

  // R9
  mag_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (mag_out == $past(mag_sel)));

  // R6
  code_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt != '0) |-> $stable(act_code));
endmodule

bind cal_pulse_gen cal_pulse_gen_chk #(.CNT_W(CNT_W), .CODE_W(CODE_W)) u_chk (
  .clk(clk), .rst_n(rst_sync_n), .enable(enable), .iso_closed(iso_closed),
  .bipolar(bipolar), .mag_sel(mag_sel), .drive_pos(drive_pos),
  .drive_neg(drive_neg), .mag_out(mag_out), .cal_blocked(cal_blocked),
  .cnt(cnt_q), .act_code(act_code_q)
);

// File: tb/sim_cal_pulse_gen.sv
`timescale 1ns/1ps
module sim_cal_pulse_gen;
  localparam int CLK_PERIOD = 40;
  localparam int Q  = CLK_PERIOD/4;
  localparam int BL = 2;

  logic clk = 1'b0;
  logic rst_n;
  logic enable, half_duty, bipolar, mag_sel, iso_closed;
  logic [2:0]  freq_code;
  logic [10:0] width_cnt;
  logic [1:0]  route_mode;
  logic drive_pos, drive_neg, mag_out, cal_blocked;
  logic [1:0] route_out;

  int checks = 0;
  int fails  = 0;
  bit checking = 0;
  bit done = 0;
  string cur_tag = "R10";

  always #(CLK_PERIOD/2) clk = ~clk;

  cal_pulse_gen #(.BASE_LOG2(BL)) u0 (
    .clk(clk), .rst_n(rst_n), .enable(enable), .freq_code(freq_code),
    .width_cnt(width_cnt), .half_duty(half_duty), .bipolar(bipolar),
    .mag_sel(mag_sel), .route_mode(route_mode), .iso_closed(iso_closed),
    .drive_pos(drive_pos), .drive_neg(drive_neg), .mag_out(mag_out),
    .route_out(route_out), .cal_blocked(cal_blocked)
  );

  function automatic int exp_period(input int k);
    return 1 << (BL + 2*k);
  endfunction

  function automatic int exp_high(input int k, input int w, input bit h);
    int half;
    half = exp_period(k) / 2;
    if (h) return half;
    return (w > half) ? half : w;
  endfunction

  task automatic chk(input bit ok, input string tag, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual=%0d expected=%0d at %0t", tag, what, act, exp, $time);
    end
  endtask

  // reference model built from the requirements (R10 two-edge release)
  logic s1, s2;
  always @(posedge clk or negedge rst_n)
    if (!rst_n) begin s1 <= 0; s2 <= 0; end
    else begin s1 <= 1; s2 <= s1; end

  int m_cnt, m_code, m_width;
  bit m_half;
  logic e_pos, e_neg, e_blk, e_mag;
  logic [1:0] e_route;

  always @(posedge clk or negedge s2) begin
    if (!s2) begin
      m_cnt <= 0; m_code <= 0; m_width <= 0; m_half <= 0;
      e_pos <= 0; e_neg <= 0; e_blk <= 0; e_mag <= 0; e_route <= 0;
    end else begin
      bit hi;
      hi = enable && (m_cnt < exp_high(m_code, m_width, m_half));
      e_pos   <= enable && !iso_closed && hi;
      e_neg   <= enable && !iso_closed && !hi && bipolar;
      e_blk   <= enable && iso_closed;
      e_mag   <= mag_sel;
      e_route <= route_mode;
      if (!enable || m_cnt == exp_period(m_code) - 1) begin
        m_cnt <= 0; m_code <= int'(freq_code); m_width <= int'(width_cnt);
        m_half <= half_duty;
      end else m_cnt <= m_cnt + 1;
    end
  end

  always @(posedge clk) begin
    #(Q);
    if (checking && !done)
      chk({drive_pos, drive_neg, cal_blocked, mag_out, route_out} ==
          {e_pos, e_neg, e_blk, e_mag, e_route}, cur_tag, "cycle outputs",
          int'({drive_pos, drive_neg, cal_blocked, mag_out, route_out}),
          int'({e_pos, e_neg, e_blk, e_mag, e_route}));
  end

  task automatic sample();
    @(posedge clk); #(Q);
  endtask

  task automatic setup(input int k, input int w, input bit h, input bit b);
    @(negedge clk);
    enable = 0; iso_closed = 0;
    freq_code = 3'(k); width_cnt = 11'(w); half_duty = h; bipolar = b;
    repeat (2) @(negedge clk);
    enable = 1;
  endtask

  task automatic measure(input int k, input int w, input bit h, input bit b,
                         input string tag);
    int p, hi, cp, cn;
    p = exp_period(k); hi = exp_high(k, w, h); cp = 0; cn = 0;
    cur_tag = tag;
    setup(k, w, h, b);
    for (int i = 0; i < p; i++) begin
      sample();
      cp += int'(drive_pos);
      cn += int'(drive_neg);
    end
    chk(cp == hi, tag, "high cycles", cp, hi);
    chk(cn == (b ? p - hi : 0), tag, "neg cycles", cn, b ? p - hi : 0);
    sample();
    // R1: next period starts exactly one period later
    chk(drive_pos == (hi > 0), "R1", "restart pos", int'(drive_pos), int'(hi > 0));
  endtask

  initial begin
    int cp;
    void'($urandom(32'd7331));
    rst_n = 0; enable = 0; freq_code = 0; width_cnt = 0; half_duty = 0;
    bipolar = 0; mag_sel = 0; route_mode = 0; iso_closed = 0;
    mag_sel = 1; route_mode = 2'd3; enable = 1;
    repeat (3) sample();
    // R10 outputs held low in reset
    chk({drive_pos, drive_neg, cal_blocked, mag_out, route_out} == 0, "R10",
        "reset outputs", int'({drive_pos, drive_neg, cal_blocked, mag_out, route_out}), 0);
    @(negedge clk); rst_n = 1;
    sample();
    chk({drive_pos, drive_neg, mag_out} == 0, "R10", "sync release",
        int'({drive_pos, drive_neg, mag_out}), 0);
    @(negedge clk); enable = 0; mag_sel = 0; route_mode = 0;
    repeat (3) @(negedge clk);
    checking = 1;

    measure(0, 1, 0, 0, "R2");
    measure(1, 5, 0, 1, "R2");
    measure(1, 0, 0, 1, "R2");
    measure(2, 2047, 0, 0, "R3");
    measure(0, 5, 0, 1, "R3");
    measure(3, 100, 0, 0, "R1");
    measure(2, 3, 1, 1, "R4");
    measure(3, 0, 1, 0, "R4");
    measure(1, 6, 0, 0, "R5");

    // R6: mid-period change waits for the boundary
    cur_tag = "R6";
    setup(1, 3, 0, 0);
    cp = 0;
    for (int i = 0; i < 21; i++) begin
      sample();
      if (i >= 5 && i <= 15) cp += int'(drive_pos);
      if (i == 16) chk(drive_pos == 1, "R6", "new period pos", int'(drive_pos), 1);
      if (i == 17) chk(drive_pos == 0, "R6", "new width end", int'(drive_pos), 0);
      if (i == 20) chk(drive_pos == 1, "R6", "new period length", int'(drive_pos), 1);
      if (i == 5) begin @(negedge clk); freq_code = 0; width_cnt = 1; end
    end
    chk(cp == 0, "R6", "old period kept", cp, 0);

    // R7: disable and restart
    cur_tag = "R7";
    @(negedge clk); enable = 0;
    sample();
    chk({drive_pos, drive_neg} == 0, "R7", "disabled strobes", int'({drive_pos, drive_neg}), 0);
    setup(1, 4, 0, 1);
    sample();
    chk(drive_pos == 1, "R7", "starts high", int'(drive_pos), 1);
    repeat (4) sample();
    chk(drive_neg == 1, "R7", "low phase at pos 4", int'(drive_neg), 1);

    // R8: interlock
    cur_tag = "R8";
    @(negedge clk); iso_closed = 1;
    sample();
    chk({cal_blocked, drive_pos, drive_neg} == 3'b100, "R8", "blocked",
        int'({cal_blocked, drive_pos, drive_neg}), 4);
    repeat (19) sample();
    chk({cal_blocked, drive_pos, drive_neg} == 3'b100, "R8", "still blocked",
        int'({cal_blocked, drive_pos, drive_neg}), 4);
    @(negedge clk); iso_closed = 0;
    repeat (20) sample();

    // R9: passthrough
    cur_tag = "R9";
    @(negedge clk); mag_sel = 1; route_mode = 2'd2;
    sample();
    chk(mag_out == 1, "R9", "mag_out", int'(mag_out), 1);
    chk(route_out == 2'd2, "R9", "route_out", int'(route_out), 2);

    // random mix checked by the model
    cur_tag = "R1 R2 R3 R4 R5 R6 R7 R8 R9";
    for (int i = 0; i < 3000; i++) begin
      @(negedge clk);
      if ($urandom % 40 == 0) enable = ~enable;
      if ($urandom % 30 == 0) iso_closed = ~iso_closed;
      if ($urandom % 10 == 0) begin
        freq_code = 3'($urandom % 3);
        width_cnt = ($urandom % 2) ? 11'($urandom % 40) : 11'($urandom % 2048);
        half_duty = 1'($urandom % 4 == 0);
      end
      bipolar = 1'($urandom % 2);
      mag_sel = 1'($urandom % 2);
      route_mode = 2'($urandom % 4);
    end
    sample();
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++; fails++;
      $display("FAIL R7 watchdog: actual=running expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule